// File: doc/BRIEF.md
# Posted Write Delivery Engine

This block pushes one buffered posted write out to a target after the initiator that supplied it has already been released. Since no one is waiting for a termination, every outcome is handled locally. A retry makes the engine try again. A disconnect makes it resume from the first undelivered DWORD. An abort, or too many attempts without full delivery, makes it drop the entry and may raise a system error.

The buffer side hands over a start address, a bus command and a DWORD count. The target side is an abstract handshake. The engine holds an attempt request with address, command and remaining count. The target answers with one result pulse that carries a termination kind and, for a disconnect, the number of DWORDs it accepted. The attempt limit is a parameter, with a default of 2^24.

Top module: `pw_deliver`

## Requirements
- R1: After reset, `req_ready` is 1, `att_valid` is 0, and `release_o`, `discard_o`, `serr_o`, `rta_flag` and `sse_flag` are all 0.
- R2: A result of kind 0 (normal) pulses `release_o` for one cycle in the cycle after the result, and the engine returns to idle.
- R3: A result of kind 1 (retry) below the limit leaves the attempt's address, command and remaining count unchanged.
- R4: A result of kind 2 (disconnect) that accepts n DWORDs, with n less than the remaining count, advances the address by 4*n and reduces the remaining count by n. If n is at least the remaining count, the entry is released as in R2.
- R5: A disconnect with n > 0 on command 4'hF (memory write and invalidate) changes the command to 4'h7 (memory write) for later attempts. With n = 0 the command is kept.
- R6: A result of kind 3 (abort) sets sticky `rta_flag` and pulses `discard_o`. Only when `serr_en` is 1 does it also pulse `serr_o` and set sticky `sse_flag`.
- R7: When the LIMIT-th attempt ends without full delivery, the entry is discarded (`discard_o` pulse, no release). `serr_o` pulses and `sse_flag` is set only if `serr_en` is 1 and `nd_disable` is 0.
- R8: `release_o` and `discard_o` are never 1 together. While an entry is in flight, `req_ready` is 0 and `req_valid` has no effect on the attempt in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Buffer offers an entry |
| req_addr | input | AW | Start byte address of the entry |
| req_cmd | input | 4 | Bus command (4'h7 or 4'hF) |
| req_dwords | input | CW | DWORD count of the entry (at least 1) |
| req_ready | output | 1 | Engine idle; the entry is taken when valid |
| serr_en | input | 1 | System-error reporting enable |
| nd_disable | input | 1 | Suppresses system error for non-delivery |
| att_valid | output | 1 | Attempt in progress |
| att_addr | output | AW | Start address of the current attempt |
| att_cmd | output | 4 | Command of the current attempt |
| att_dwords | output | CW | DWORDs still to deliver |
| res_valid | input | 1 | Target result for the current attempt |
| res_kind | input | 2 | 0 normal, 1 retry, 2 disconnect, 3 abort |
| res_count | input | CW | DWORDs accepted (disconnect only) |
| release_o | output | 1 | Entry fully delivered (one-cycle pulse) |
| discard_o | output | 1 | Entry abandoned (one-cycle pulse) |
| serr_o | output | 1 | System error (one-cycle pulse) |
| rta_flag | output | 1 | Sticky received-target-abort flag |
| sse_flag | output | 1 | Sticky signaled-system-error flag |

## Verification
The delicate coincidence is a partial disconnect that arrives on the LIMIT-th attempt. In that one cycle the restart arithmetic (address advance and command downgrade) and the non-delivery decision both apply. The bench reaches this case with three retries followed by a partial disconnect, using a limit of 4. It then requires a discard with a system error, no release, and no further attempt at the advanced address.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
    typedef enum logic [1:0] {
        RES_DONE  = 2'd0,
        RES_RETRY = 2'd1,
        RES_DISC  = 2'd2,
        RES_ABORT = 2'd3
    } res_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } st_e;

    localparam logic [3:0] CMD_MEMWR = 4'h7;
    localparam logic [3:0] CMD_MWI   = 4'hF;
endpackage

// File: rtl/pwd_restart.sv
module pwd_restart #(
    parameter int AW = 32,
    parameter int CW = 8
) (
    input  logic [AW-1:0] cur_addr,
    input  logic [3:0]    cur_cmd,
    input  logic [CW-1:0] cur_rem,
    input  logic [CW-1:0] acc,
    output logic [AW-1:0] nxt_addr,
    output logic [3:0]    nxt_cmd,
    output logic [CW-1:0] nxt_rem,
    output logic          all_done
);
    import pwd_pkg::*;

    always_comb begin
        all_done = (acc >= cur_rem);
        nxt_addr = cur_addr + (AW'(acc) << 2);
        nxt_rem  = cur_rem - acc;
        nxt_cmd  = ((acc != '0) && (cur_cmd == CMD_MWI)) ? CMD_MEMWR : cur_cmd;
    end
endmodule

// File: rtl/pwd_limit.sv
module pwd_limit #(
    parameter int LIMIT = 1 << 24,
    parameter int NW    = 25
) (
    input  logic [NW-1:0] cnt,
    output logic [NW-1:0] nxt_cnt,
    output logic          hit
);
    localparam logic [NW-1:0] LIM_V = NW'(LIMIT);

    always_comb begin
        nxt_cnt = cnt + 1'b1;
        hit     = (nxt_cnt >= LIM_V);
    end
endmodule

// File: rtl/pwd_err.sv
module pwd_err (
    input  logic abort_ev,
    input  logic nodel_ev,
    input  logic serr_en,
    input  logic nd_disable,
    output logic set_rta,
    output logic raise_serr
);
    always_comb begin
        set_rta    = abort_ev;
        raise_serr = (abort_ev && serr_en) || (nodel_ev && serr_en && !nd_disable);
    end
endmodule

// File: rtl/pw_deliver.sv
module pw_deliver #(
    parameter int AW    = 32,
    parameter int CW    = 8,
    parameter int LIMIT = 1 << 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [3:0]    req_cmd,
    input  logic [CW-1:0] req_dwords,
    output logic          req_ready,
    input  logic          serr_en,
    input  logic          nd_disable,
    output logic          att_valid,
    output logic [AW-1:0] att_addr,
    output logic [3:0]    att_cmd,
    output logic [CW-1:0] att_dwords,
    input  logic          res_valid,
    input  logic [1:0]    res_kind,
    input  logic [CW-1:0] res_count,
    output logic          release_o,
    output logic          discard_o,
    output logic          serr_o,
    output logic          rta_flag,
    output logic          sse_flag
);
    import pwd_pkg::*;

    localparam int NW = $clog2(LIMIT + 1);

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] addr;
        logic [3:0]    cmd;
        logic [CW-1:0] rem;
        logic [NW-1:0] tries;
        logic          rel;
        logic          dis;
        logic          serr;
        logic          rta;
        logic          sse;
    } state_t;

    state_t s_q, s_d;

    logic [CW-1:0] acc;
    logic [AW-1:0] rs_addr;
    logic [3:0]    rs_cmd;
    logic [CW-1:0] rs_rem;
    logic          rs_done;
    logic [NW-1:0] lim_nxt;
    logic          lim_hit;
    logic          got_res;
    logic          abort_ev;
    logic          nodel_ev;
    logic          set_rta;
    logic          raise_serr;

    always_comb begin
        got_res  = (s_q.st == ST_BUSY) && res_valid;
        acc      = (res_kind == RES_DISC) ? res_count : '0;
        abort_ev = got_res && (res_kind == RES_ABORT);
        nodel_ev = got_res && lim_hit &&
                   ((res_kind == RES_RETRY) || ((res_kind == RES_DISC) && !rs_done));
    end

    pwd_restart #(.AW(AW), .CW(CW)) u_restart (
        .cur_addr (s_q.addr),
        .cur_cmd  (s_q.cmd),
        .cur_rem  (s_q.rem),
        .acc      (acc),
        .nxt_addr (rs_addr),
        .nxt_cmd  (rs_cmd),
        .nxt_rem  (rs_rem),
        .all_done (rs_done)
    );

    pwd_limit #(.LIMIT(LIMIT), .NW(NW)) u_limit (
        .cnt     (s_q.tries),
        .nxt_cnt (lim_nxt),
        .hit     (lim_hit)
    );

    pwd_err u_err (
        .abort_ev   (abort_ev),
        .nodel_ev   (nodel_ev),
        .serr_en    (serr_en),
        .nd_disable (nd_disable),
        .set_rta    (set_rta),
        .raise_serr (raise_serr)
    );

    always_comb begin
        s_d      = s_q;
        s_d.rel  = 1'b0;
        s_d.dis  = 1'b0;
        s_d.serr = raise_serr;
        s_d.rta  = s_q.rta | set_rta;
        s_d.sse  = s_q.sse | raise_serr;
        if (s_q.st == ST_IDLE) begin
            if (req_valid) begin
                s_d.st    = ST_BUSY;
                s_d.addr  = req_addr;
                s_d.cmd   = req_cmd;
                s_d.rem   = req_dwords;
                s_d.tries = '0;
            end
        end else if (res_valid) begin
            unique case (res_kind)
                RES_DONE: begin
                    s_d.rel = 1'b1;
                    s_d.st  = ST_IDLE;
                end
                RES_ABORT: begin
                    s_d.dis = 1'b1;
                    s_d.st  = ST_IDLE;
                end
                default: begin
                    if ((res_kind == RES_DISC) && rs_done) begin
                        s_d.rel = 1'b1;
                        s_d.st  = ST_IDLE;
                    end else if (lim_hit) begin
                        s_d.dis = 1'b1;
                        s_d.st  = ST_IDLE;
                    end else begin
                        s_d.tries = lim_nxt;
                        s_d.addr  = rs_addr;
                        s_d.cmd   = rs_cmd;
                        s_d.rem   = rs_rem;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        req_ready  = (s_q.st == ST_IDLE);
        att_valid  = (s_q.st == ST_BUSY);
        att_addr   = s_q.addr;
        att_cmd    = s_q.cmd;
        att_dwords = s_q.rem;
        release_o  = s_q.rel;
        discard_o  = s_q.dis;
        serr_o     = s_q.serr;
        rta_flag   = s_q.rta;
        sse_flag   = s_q.sse;
    end
endmodule

// File: rtl/pwd_checker.sv
module pwd_checker #(
    parameter int AW = 32,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          serr_en,
    input logic          att_valid,
    input logic [AW-1:0] att_addr,
    input logic [3:0]    att_cmd,
    input logic          res_valid,
    input logic [1:0]    res_kind,
    input logic [CW-1:0] res_count,
    input logic          release_o,
    input logic          discard_o,
    input logic          serr_o,
    input logic          rta_flag,
    input logic          sse_flag
);
    assert_done_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (att_valid && res_valid && res_kind == 2'd0) |=> (release_o && !att_valid));

    assert_retry_same_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (att_valid && res_valid && res_kind == 2'd1) |=>
        (!att_valid || (att_addr == $past(att_addr) && att_cmd == $past(att_cmd))));

    assert_disc_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (att_valid && res_valid && res_kind == 2'd2) |=>
        (!att_valid || att_addr == $past(att_addr) + (AW'($past(res_count)) << 2)));

    assert_downgrade_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (att_valid && res_valid && res_kind == 2'd2 && res_count != '0 && att_cmd == 4'hF) |=>
        (!att_valid || att_cmd == 4'h7));

    assert_abort_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (att_valid && res_valid && res_kind == 2'd3) |=>
        (rta_flag && discard_o && (serr_o == $past(serr_en))));

    assert_serr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> sse_flag);

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({release_o, discard_o}));

    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (att_valid && req_valid && !res_valid) |=> (att_valid && $stable(att_addr)));

    assert_ready_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready != att_valid);
endmodule

bind pw_deliver pwd_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .serr_en   (serr_en),
    .att_valid (att_valid),
    .att_addr  (att_addr),
    .att_cmd   (att_cmd),
    .res_valid (res_valid),
    .res_kind  (res_kind),
    .res_count (res_count),
    .release_o (release_o),
    .discard_o (discard_o),
    .serr_o    (serr_o),
    .rta_flag  (rta_flag),
    .sse_flag  (sse_flag)
);

// File: tb/tb_pw_deliver.sv
module tb_pw_deliver;
    localparam int AW = 32;
    localparam int CW = 8;
    localparam int LIM = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_cmd = '0;
    logic [CW-1:0] req_dwords = '0;
    logic          req_ready;
    logic          serr_en = 1'b1;
    logic          nd_disable = 1'b0;
    logic          att_valid;
    logic [AW-1:0] att_addr;
    logic [3:0]    att_cmd;
    logic [CW-1:0] att_dwords;
    logic          res_valid = 1'b0;
    logic [1:0]    res_kind = '0;
    logic [CW-1:0] res_count = '0;
    logic          release_o, discard_o, serr_o, rta_flag, sse_flag;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pw_deliver #(.AW(AW), .CW(CW), .LIMIT(LIM)) dut (.*);

    // reference model state
    bit      m_busy, m_rel, m_dis, m_serr, m_rta, m_sse;
    longint  m_addr;
    int      m_cmd, m_rem, m_tries;

    always @(posedge clk) begin
        int acc;
        if (!rst_n) begin
            m_busy = 0; m_rel = 0; m_dis = 0; m_serr = 0; m_rta = 0; m_sse = 0;
            m_addr = 0; m_cmd = 0; m_rem = 0; m_tries = 0;
        end else begin
            m_rel = 0; m_dis = 0; m_serr = 0;
            if (!m_busy) begin
                if (req_valid) begin
                    m_busy = 1; m_addr = req_addr; m_cmd = req_cmd;
                    m_rem = req_dwords; m_tries = 0;
                end
            end else if (res_valid) begin
                if (res_kind == 0) begin
                    m_rel = 1; m_busy = 0;
                end else if (res_kind == 3) begin
                    m_rta = 1; m_dis = 1; m_busy = 0;
                    if (serr_en) begin m_serr = 1; m_sse = 1; end
                end else begin
                    acc = (res_kind == 2) ? int'(res_count) : 0;
                    if (res_kind == 2 && acc >= m_rem) begin
                        m_rel = 1; m_busy = 0;
                    end else begin
                        m_tries++;
                        if (m_tries >= LIM) begin
                            m_dis = 1; m_busy = 0;
                            if (serr_en && !nd_disable) begin m_serr = 1; m_sse = 1; end
                        end else begin
                            m_addr = (m_addr + 4 * acc) & 64'hFFFF_FFFF;
                            m_rem = m_rem - acc;
                            if (acc > 0 && m_cmd == 15) m_cmd = 7;
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R8 att_valid", att_valid, m_busy);
            chk("R1 req_ready", req_ready, !m_busy);
            if (m_busy) begin
                chk("R4 att_addr", att_addr, m_addr);
                chk("R5 att_cmd", att_cmd, m_cmd);
                chk("R4 att_dwords", att_dwords, m_rem);
            end
            chk("R2 release", release_o, m_rel);
            chk("R7 discard", discard_o, m_dis);
            chk("R6 serr", serr_o, m_serr);
            chk("R6 rta", rta_flag, m_rta);
            chk("R7 sse", sse_flag, m_sse);
        end
    end

    task automatic push(input logic [AW-1:0] a, input logic [3:0] c, input int n);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_addr = a; req_cmd = c; req_dwords = CW'(n);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic resp(input logic [1:0] k, input int n);
        while (!att_valid) @(negedge clk);
        res_valid = 1; res_kind = k; res_count = CW'(n);
        @(negedge clk);
        res_valid = 0; res_count = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset ready", req_ready, 1);
        chk("R1 reset att", att_valid, 0);
        chk("R1 reset flags", {release_o, discard_o, serr_o, rta_flag, sse_flag}, 0);
        rst_n = 1;

        // R2 normal completion
        push(32'h1000, 4'h7, 4);
        resp(2'd0, 0);
        chk("R2 release pulse", release_o, 1);
        chk("R2 idle", req_ready, 1);
        @(negedge clk);
        chk("R2 pulse one cycle", release_o, 0);

        // R3 / R4 / R5 restart sequence
        push(32'h2000, 4'hF, 8);
        resp(2'd1, 0);
        chk("R3 retry addr", att_addr, 32'h2000);
        chk("R3 retry cmd", att_cmd, 4'hF);
        resp(2'd2, 0);
        chk("R5 zero-accept keeps MWI", att_cmd, 4'hF);
        resp(2'd2, 3);
        chk("R4 disc addr", att_addr, 32'h200C);
        chk("R4 disc rem", att_dwords, 5);
        chk("R5 downgrade", att_cmd, 4'h7);
        // R8 request while busy is ignored
        req_valid = 1; req_addr = 32'h9999_0000; req_cmd = 4'h7; req_dwords = 2;
        @(negedge clk);
        req_valid = 0;
        chk("R8 busy ignores req", att_addr, 32'h200C);
        resp(2'd2, 5);
        chk("R4 full disc release", release_o, 1);
        chk("R8 no discard with release", discard_o, 0);

        // R7 limit coinciding with a partial disconnect
        push(32'h3000, 4'hF, 6);
        resp(2'd1, 0); resp(2'd1, 0); resp(2'd1, 0);
        resp(2'd2, 2);
        chk("R7 discard at limit", discard_o, 1);
        chk("R7 no release", release_o, 0);
        chk("R7 serr", serr_o, 1);
        chk("R7 sse", sse_flag, 1);
        chk("R7 idle", att_valid, 0);

        // R7 with non-delivery reporting disabled
        nd_disable = 1;
        push(32'h4000, 4'h7, 2);
        repeat (4) resp(2'd1, 0);
        chk("R7 masked discard", discard_o, 1);
        chk("R7 masked serr", serr_o, 0);
        nd_disable = 0;

        // R6 abort with reporting off then on
        serr_en = 0;
        push(32'h5000, 4'h7, 3);
        resp(2'd3, 0);
        chk("R6 rta", rta_flag, 1);
        chk("R6 discard", discard_o, 1);
        chk("R6 no serr", serr_o, 0);
        serr_en = 1;
        push(32'h6000, 4'h7, 3);
        resp(2'd3, 0);
        chk("R6 serr", serr_o, 1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule